// File: doc/BRIEF.md
# Sticky Edge-Pixel Coverage Counter Array

This block keeps one small saturating counter for every slot of a pool of supersampled edge pixels. The counters tell the pixel back end when a pixel that was promoted to full supersampling can fall back to a single sample. Triangle edges that cross a pixel arrive as events. An edge that opens coverage raises the count and an edge that closes coverage lowers it. A discontinuity edge pins the count at its maximum. Once pinned, the pixel stays supersampled for good.

One event is accepted per clock. Each event carries a slot index and a 3-bit kind. The block reads the addressed counter, applies the rule for that kind and writes the result back. Two rising edges after the event is presented, it reports one of two things: a collapse for that slot, or an underflow error. Events that follow each other on the same slot see each other's updates through a forwarding path, so no stall is needed.

Top module: `ecnt_array`

## Requirements
- R1: After reset every counter is zero and `collapse_o` and `underflow_o` are low.
- R2: Kind 1 (opening edge) adds one to the addressed counter, and kind 2 (closing edge) subtracts one from it.
- R3: Kind 3 (discontinuity edge) sets the addressed counter to its maximum, 15 for 4-bit counters.
- R4: A counter at its maximum is frozen: kinds 1 and 2 leave it at the maximum and produce no output.
- R5: A kind 2 event that takes a counter from one to zero raises `collapse_o` for one cycle, with that slot on `collapse_slot_o`.
- R6: Kind 4 (full coverage by a non-edge fragment) raises `collapse_o` with the slot and clears the counter to zero, even when the counter is frozen.
- R7: Kind 0 (allocate) clears the addressed counter to zero and produces no output.
- R8: A kind 2 event on a counter that is already zero leaves the counter at zero, raises `underflow_o` with the slot on `collapse_slot_o`, and does not raise `collapse_o`.
- R9: Outputs for an event appear after the second rising edge that follows its presentation. A back-to-back event on the same slot operates on the value left by the previous event. A cycle with `ev_valid_i` low changes nothing and reports nothing.
- R10: Kind codes 5, 6 and 7 are reserved. They leave the counter unchanged and produce no output.
- R11: Counters of different slots are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | 1 | An event is presented this cycle |
| ev_slot_i | input | SLOT_W | Target pixel slot |
| ev_kind_i | input | 3 | Event kind: 0 allocate, 1 open, 2 close, 3 discontinuity, 4 full cover |
| collapse_o | output | 1 | Slot may drop to a single sample |
| collapse_slot_o | output | SLOT_W | Slot of the current collapse or underflow report |
| underflow_o | output | 1 | A close was applied to a zero counter |

## Verification
The bench instantiates the block with 8 slots of 4-bit counters. With 4-bit counters the maximum of 15 is reached after only fifteen opening edges, so the bench can drive a counter into the frozen state by increments as well as by a discontinuity edge, and then try to push it past that state. With 8 slots, every counter can be probed right after reset, and events to the first and last slot can be interleaved. Close events on zero counters are the probe that brings the hidden counter value out to the ports.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;
  typedef enum logic [2:0] {
    EV_ALLOC = 3'd0,
    EV_OPEN  = 3'd1,
    EV_CLOSE = 3'd2,
    EV_DISC  = 3'd3,
    EV_COVER = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/ecnt_update.sv
module ecnt_update
  import ecnt_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [2:0]       kind_i,
  input  logic [CNT_W-1:0] cur_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             collapse_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic frozen;
  assign frozen = (cur_i == CMAX);

  always_comb begin
    nxt_o       = cur_i;
    collapse_o  = 1'b0;
    underflow_o = 1'b0;
    case (kind_i)
      EV_ALLOC: nxt_o = '0;
      EV_OPEN: begin
        if (!frozen) nxt_o = cur_i + CONE;
      end
      EV_CLOSE: begin
        if (!frozen) begin
          if (cur_i == '0) begin
            underflow_o = 1'b1;
          end else begin
            nxt_o      = cur_i - CONE;
            collapse_o = (cur_i == CONE);
          end
        end
      end
      EV_DISC: nxt_o = CMAX;
      EV_COVER: begin
        nxt_o      = '0;
        collapse_o = 1'b1;
      end
      default: nxt_o = cur_i;  // reserved codes
    endcase
  end
endmodule

// File: rtl/ecnt_store.sv
module ecnt_store #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SLOT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [CNT_W-1:0]  wr_data_i
);
  logic [CNT_W-1:0] cnt_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (we_i && (wr_slot_i == SLOT_W'(g))) begin
        cnt_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_slot_i == SLOT_W'(i)) rd_data_o = cnt_q[i];
    end
  end
endmodule

// File: rtl/ecnt_out.sv
module ecnt_out #(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              collapse_i,
  input  logic              underflow_i,
  output logic              collapse_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              underflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      collapse_o  <= 1'b0;
      underflow_o <= 1'b0;
      slot_o      <= '0;
    end else begin
      collapse_o  <= vld_i && collapse_i;
      underflow_o <= vld_i && underflow_i;
      if (vld_i) slot_o <= slot_i;
    end
  end
endmodule

// File: rtl/ecnt_array.sv
module ecnt_array #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned CNT_W     = 4,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  input  logic [2:0]        ev_kind_i,
  output logic              collapse_o,
  output logic [SLOT_W-1:0] collapse_slot_o,
  output logic              underflow_o
);
  logic              s1_vld;
  logic [SLOT_W-1:0] s1_slot;
  logic [2:0]        s1_kind;
  logic [CNT_W-1:0]  s1_cur;

  logic [CNT_W-1:0]  store_rd;
  logic [CNT_W-1:0]  upd_nxt;
  logic              upd_col;
  logic              upd_unf;
  logic              fwd_hit;
  logic [CNT_W-1:0]  cur_in;

  ecnt_store #(
    .NUM_SLOTS(NUM_SLOTS),
    .CNT_W    (CNT_W),
    .SLOT_W   (SLOT_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_slot_i(ev_slot_i),
    .rd_data_o(store_rd),
    .we_i     (s1_vld),
    .wr_slot_i(s1_slot),
    .wr_data_i(upd_nxt)
  );

  // write-back of the event in flight lands one edge late; bypass it
  assign fwd_hit = s1_vld && (s1_slot == ev_slot_i);
  assign cur_in  = fwd_hit ? upd_nxt : store_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_slot <= '0;
      s1_kind <= '0;
      s1_cur  <= '0;
    end else begin
      s1_vld <= ev_valid_i;
      if (ev_valid_i) begin
        s1_slot <= ev_slot_i;
        s1_kind <= ev_kind_i;
        s1_cur  <= cur_in;
      end
    end
  end

  ecnt_update #(
    .CNT_W(CNT_W)
  ) u_update (
    .kind_i     (s1_kind),
    .cur_i      (s1_cur),
    .nxt_o      (upd_nxt),
    .collapse_o (upd_col),
    .underflow_o(upd_unf)
  );

  ecnt_out #(
    .SLOT_W(SLOT_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (s1_vld),
    .slot_i     (s1_slot),
    .collapse_i (upd_col),
    .underflow_i(upd_unf),
    .collapse_o (collapse_o),
    .slot_o     (collapse_slot_o),
    .underflow_o(underflow_o)
  );
endmodule

// File: rtl/ecnt_array_chk.sv
module ecnt_array_chk
  import ecnt_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s1_vld,
  input logic [2:0]       s1_kind,
  input logic [CNT_W-1:0] s1_cur,
  input logic [CNT_W-1:0] upd_nxt,
  input logic             collapse_o,
  input logic             underflow_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_disc_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_kind == EV_DISC) |-> (upd_nxt == CMAX));

  p_frozen_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_cur == CMAX && (s1_kind == EV_OPEN || s1_kind == EV_CLOSE))
      |=> (!collapse_o && !underflow_o));

  p_frozen_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_cur == CMAX && (s1_kind == EV_OPEN || s1_kind == EV_CLOSE))
      |-> (upd_nxt == CMAX));

  p_collapse_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collapse_o |-> ($past(s1_vld) && ($past(s1_kind) == EV_COVER ||
                    ($past(s1_kind) == EV_CLOSE && $past(s1_cur) == CONE))));

  p_underflow_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $past(s1_vld && s1_kind == EV_CLOSE && s1_cur == '0));

  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(collapse_o && underflow_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld |=> (!collapse_o && !underflow_o));

  p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_kind > EV_COVER) |-> (upd_nxt == s1_cur));
endmodule

bind ecnt_array ecnt_array_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s1_vld     (s1_vld),
  .s1_kind    (s1_kind),
  .s1_cur     (s1_cur),
  .upd_nxt    (upd_nxt),
  .collapse_o (collapse_o),
  .underflow_o(underflow_o)
);

// File: tb/ecnt_array_test.sv
`timescale 1ns/1ps
module ecnt_array_test;
  localparam int NS = 8;
  localparam int SW = 3;
  localparam int MAXV = 15;
  localparam logic [2:0] K_ALLOC = 3'd0, K_OPEN = 3'd1, K_CLOSE = 3'd2,
                         K_DISC = 3'd3, K_COVER = 3'd4;

  typedef struct {
    bit    col;
    bit    unf;
    int    slot;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ev_valid = 1'b0;
  logic [SW-1:0] ev_slot = '0;
  logic [2:0]    ev_kind = '0;
  logic          collapse_o;
  logic [SW-1:0] collapse_slot_o;
  logic          underflow_o;

  int   total = 0;
  int   bad = 0;
  int   model [NS];
  exp_t q [$];
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ecnt_array #(.NUM_SLOTS(NS), .CNT_W(4)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .ev_valid_i     (ev_valid),
    .ev_slot_i      (ev_slot),
    .ev_kind_i      (ev_kind),
    .collapse_o     (collapse_o),
    .collapse_slot_o(collapse_slot_o),
    .underflow_o    (underflow_o)
  );

  // driver: one event (or idle) per cycle, expected outcome queued
  task automatic step(input bit v, input logic [2:0] k, input int s, input string tag);
    exp_t e;
    @(negedge clk);
    ev_valid = v;
    ev_kind  = k;
    ev_slot  = SW'(s);
    e.col = 0; e.unf = 0; e.slot = s; e.tag = tag;
    if (v) begin
      case (k)
        K_ALLOC: model[s] = 0;
        K_OPEN:  if (model[s] != MAXV) model[s]++;
        K_CLOSE: if (model[s] != MAXV) begin
                   if (model[s] == 0) e.unf = 1;
                   else begin
                     model[s]--;
                     e.col = (model[s] == 0);
                   end
                 end
        K_DISC:  model[s] = MAXV;
        K_COVER: begin model[s] = 0; e.col = 1; end
        default: ;
      endcase
    end
    q.push_back(e);
  endtask

  task automatic rep(input int n, input logic [2:0] k, input int s, input string tag);
    for (int i = 0; i < n; i++) step(1, k, s, tag);
  endtask

  // monitor: outputs of an event show two edges after it was driven
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() >= 2) begin
        e = q.pop_front();
        total++;
        if (collapse_o !== e.col || underflow_o !== e.unf ||
            ((e.col || e.unf) && int'(collapse_slot_o) != e.slot)) begin
          bad++;
          $display("FAIL %s: col=%0b unf=%0b slot=%0d expected col=%0b unf=%0b slot=%0d",
                   e.tag, collapse_o, underflow_o, collapse_slot_o, e.col, e.unf, e.slot);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    total++;
    if (collapse_o !== 1'b0 || underflow_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: col=%0b unf=%0b expected 0 0", collapse_o, underflow_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: every counter starts at zero, so a close underflows
    for (int s = 0; s < NS; s++) step(1, K_CLOSE, s, "R1");

    // R2 R5 R9: back-to-back on one slot
    step(1, K_ALLOC, 2, "R7");
    rep(3, K_OPEN, 2, "R9");
    rep(3, K_CLOSE, 2, "R5");

    // R2: same with idle gaps
    step(1, K_OPEN, 2, "R2"); step(0, K_OPEN, 2, "R9");
    step(1, K_OPEN, 2, "R2"); step(0, K_CLOSE, 2, "R9");
    step(1, K_CLOSE, 2, "R2"); step(0, K_CLOSE, 2, "R9");
    step(1, K_CLOSE, 2, "R5");

    // R7: allocate clears a nonzero counter
    rep(5, K_OPEN, 4, "R2");
    step(1, K_ALLOC, 4, "R7");
    step(1, K_CLOSE, 4, "R7");

    // R8: underflow leaves zero
    step(1, K_CLOSE, 5, "R8");
    step(1, K_OPEN, 5, "R8");
    step(1, K_CLOSE, 5, "R8");

    // R3 R4 R6: discontinuity freezes, cover releases
    step(1, K_OPEN, 3, "R3");
    step(1, K_DISC, 3, "R3");
    rep(16, K_CLOSE, 3, "R4");
    rep(2, K_OPEN, 3, "R4");
    step(1, K_COVER, 3, "R6");
    step(1, K_CLOSE, 3, "R6");

    // R4: saturation reached by increments
    step(1, K_ALLOC, 6, "R7");
    rep(17, K_OPEN, 6, "R4");
    rep(20, K_CLOSE, 6, "R4");
    step(1, K_COVER, 6, "R6");
    step(1, K_OPEN, 6, "R6");
    step(1, K_CLOSE, 6, "R6");

    // R10: reserved kinds change nothing
    step(1, K_OPEN, 1, "R10");
    step(1, 3'd5, 1, "R10");
    step(1, 3'd6, 1, "R10");
    step(1, 3'd7, 1, "R10");
    step(1, K_CLOSE, 1, "R10");

    // R11: interleaved slots
    step(1, K_OPEN, 0, "R11");
    step(1, K_OPEN, 7, "R11");
    step(1, K_OPEN, 7, "R11");
    step(1, K_CLOSE, 0, "R11");
    step(1, K_CLOSE, 7, "R11");
    step(1, K_CLOSE, 7, "R11");
    step(1, K_DISC, 0, "R11");
    step(1, K_CLOSE, 7, "R11");
    step(1, K_COVER, 0, "R6");

    // R9: invalid cycle ignored, then check slot 0 still zero
    step(0, K_OPEN, 0, "R9");
    step(1, K_CLOSE, 0, "R9");

    repeat (4) step(0, K_ALLOC, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule